// File: doc/BRIEF.md
# Chainable Up-Counter Timer with Trigger Output Selector

This block is a kernel-clocked up-counter. A programmable prescaler sets how often it counts. It wraps to zero after reaching an auto-reload limit, and one compare channel turns the count into a reference waveform. A 3-bit trigger-source field picks what drives the shared trigger output. It can be a one-clock pulse on every wrap, which lets a downstream timer use this timer's overflow as its clock. It can instead be the level of the compare reference, which lets a downstream timer be clocked or gated by that waveform.

Software programs the block through a small write port. Address 0 is the control word, address 1 the prescaler, address 2 the auto-reload limit and address 3 the compare value. While the timer runs, the prescaler and auto-reload values are buffered and take effect at the next wrap. While the timer is stopped, they take effect at once.

Top module: `trig_timer`

## Requirements
- R1: After reset the counter reads 0, the trigger output is 0 and the compare reference is 0. Reset state: stopped, trigger source 3'b000, compare mode 0, prescaler 0, compare 0, auto-reload all ones.
- R2: While enabled, the counter steps by one on every prescaler tick. On a tick taken at the auto-reload value it goes to 0 instead; this is the update event.
- R3: With an effective prescaler value P, a tick occurs once every P+1 kernel clocks, so P=2 gives one count every third clock.
- R4: With trigger source 3'b010, the trigger output is high for exactly the one clock following each update event, which is the clock in which the counter first reads 0. With auto-reload 9 and prescaler 2, the pulses are 30 clocks apart.
- R5: With any trigger source 3'b1xx, the trigger output equals the compare reference in every cycle.
- R6: With trigger source 3'b000, 3'b001 or 3'b011, the trigger output stays 0.
- R7: Compare mode 0 holds the reference at 0 and mode 1 holds it at 1. In mode 2 the reference is high while counter < compare. In mode 3 it is high while counter >= compare.
- R8: A prescaler or auto-reload write made while enabled changes nothing until the next update event. From that event on, the new value governs.
- R9: While the enable bit is 0, the counter and the prescaler phase hold their values and no trigger pulse occurs.
- R10: A write on a clock edge takes effect from the next cycle. Address 0 holds enable in bit 0, trigger source in bits 3:1 and compare mode in bits 5:4. Addresses 1, 2 and 3 hold prescaler, auto-reload and compare. A compare write is seen by the reference in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig_out | output | 1 | Selected trigger for downstream timers |
| cmp_ref | output | 1 | Compare reference waveform |
| cnt_out | output | 16 | Current counter value |

## Verification
The counter, the prescaler phase and the update flag are registers. A write or a tick at a clock edge is therefore visible on `cnt_out` one edge later. The update pulse appears in that same cycle, when the counter first reads 0. The trigger output and the compare reference are combinational from these registers, so they change in the cycle after the edge that caused the change. The bench steps an integer reference model on each rising edge, using the inputs present before that edge. It compares all three outputs on the following falling edge, so every result is sampled in the cycle it is due. Directed checks add timing of the pulse spacing, the cycle-exact switch to a new prescaler, and holding while stopped.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
   typedef enum logic [1:0] {
      CMP_FORCE_LO = 2'd0,
      CMP_FORCE_HI = 2'd1,
      CMP_PWM      = 2'd2,
      CMP_PWM_INV  = 2'd3
   } cmp_mode_e;

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_PSC  = 2'd1;
   localparam logic [1:0] ADR_ARR  = 2'd2;
   localparam logic [1:0] ADR_CMP  = 2'd3;

   localparam logic [2:0] SRC_OFF    = 3'b000;
   localparam logic [2:0] SRC_UPDATE = 3'b010;
endpackage

// File: rtl/trig_timer_prescaler.sv
module trig_timer_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload,
   input  logic [PSC_W-1:0] psc_pre,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;
   logic [PSC_W-1:0] psc_sh;

   generate
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_w
         $error("trig_timer_prescaler: PSC_W out of range");
      end
   endgenerate

   assign tick = run && (phase_q >= psc_sh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         psc_sh  <= '0;
      end else begin
         if (run) phase_q <= tick ? '0 : phase_q + 1'b1;
         if (reload) psc_sh <= psc_pre;
      end
   end

   AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(phase_q)); // R9
endmodule

// File: rtl/trig_timer_counter.sv
module trig_timer_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] arr_pre,
   output logic [CNT_W-1:0] cnt,
   output logic             upd_now,
   output logic             upd_flag
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] arr_sh;
   logic             upd_q;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("trig_timer_counter: CNT_W out of range");
      end
   endgenerate

   assign upd_now  = run && tick && (cnt_q == arr_sh);
   assign cnt      = cnt_q;
   assign upd_flag = upd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         arr_sh <= '1;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= upd_now;
         if (upd_now) cnt_q <= '0;
         else if (run && tick) cnt_q <= cnt_q + 1'b1;
         if (upd_now || !run) arr_sh <= arr_pre;
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt_q)); // R9
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0))); // R2
   AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (cnt_q == '0)); // R4
   AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_q && arr_sh != '0) |=> !upd_q); // R4
endmodule

// File: rtl/trig_timer_compare.sv
module trig_timer_compare
   import trig_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_INV = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  cmp_mode_e        mode,
   output logic             ref_o
);
   logic below;
   assign below = cnt < cmp_val;

   generate
      if (HAS_INV) begin : g_inv
         always_comb begin
            unique case (mode)
               CMP_FORCE_LO: ref_o = 1'b0;
               CMP_FORCE_HI: ref_o = 1'b1;
               CMP_PWM:      ref_o = below;
               default:      ref_o = !below;
            endcase
         end
      end else begin : g_noinv
         always_comb begin
            unique case (mode)
               CMP_FORCE_LO: ref_o = 1'b0;
               CMP_FORCE_HI: ref_o = 1'b1;
               default:      ref_o = below;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/trig_timer_trgsel.sv
module trig_timer_trgsel
   import trig_timer_pkg::*;
(
   input  logic [2:0] src,
   input  logic       upd_flag,
   input  logic       ref_i,
   output logic       trig
);
   always_comb begin
      if (src[2]) trig = ref_i;
      else if (src == SRC_UPDATE) trig = upd_flag;
      else trig = 1'b0;
   end
endmodule

// File: rtl/trig_timer.sv
module trig_timer
   import trig_timer_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 16,
   parameter int DATA_W  = 16,
   parameter bit HAS_INV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              trig_out,
   output logic              cmp_ref,
   output logic [CNT_W-1:0]  cnt_out
);
   localparam int CTRL_W = 6;

   generate
      if (DATA_W < CNT_W || DATA_W < PSC_W || DATA_W < CTRL_W) begin : g_bad_data
         $error("trig_timer: DATA_W too narrow");
      end
   endgenerate

   logic             en_q;
   logic [2:0]       src_q;
   cmp_mode_e        mode_q;
   logic [PSC_W-1:0] psc_pre_q;
   logic [CNT_W-1:0] arr_pre_q;
   logic [CNT_W-1:0] cmp_q;
   logic             tick;
   logic             upd_now;
   logic             upd_flag;
   logic [CNT_W-1:0] cnt;
   logic             ref_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         src_q     <= SRC_OFF;
         mode_q    <= CMP_FORCE_LO;
         psc_pre_q <= '0;
         arr_pre_q <= '1;
         cmp_q     <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADR_CTRL: begin
               en_q   <= wr_data[0];
               src_q  <= wr_data[3:1];
               mode_q <= cmp_mode_e'(wr_data[5:4]);
            end
            ADR_PSC: psc_pre_q <= wr_data[PSC_W-1:0];
            ADR_ARR: arr_pre_q <= wr_data[CNT_W-1:0];
            default: cmp_q     <= wr_data[CNT_W-1:0];
         endcase
      end
   end

   trig_timer_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(en_q), .reload(upd_now || !en_q),
      .psc_pre(psc_pre_q), .tick(tick));

   trig_timer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick), .arr_pre(arr_pre_q),
      .cnt(cnt), .upd_now(upd_now), .upd_flag(upd_flag));

   trig_timer_compare #(.CNT_W(CNT_W), .HAS_INV(HAS_INV)) u_cmp (
      .cnt(cnt), .cmp_val(cmp_q), .mode(mode_q), .ref_o(ref_w));

   trig_timer_trgsel u_sel (
      .src(src_q), .upd_flag(upd_flag), .ref_i(ref_w), .trig(trig_out));

   assign cmp_ref = ref_w;
   assign cnt_out = cnt;

   AST_NO_PULSE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && src_q == SRC_UPDATE) |=> !trig_out); // R9
   AST_TRG_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      src_q[2] |-> (trig_out == cmp_ref)); // R5
endmodule

// File: tb/trig_timer_bench.sv
module trig_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        trig_out, cmp_ref;
   logic [15:0] cnt_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;

   int m_en, m_src, m_mode, m_psc_pre, m_psc_sh, m_arr_pre, m_arr_sh, m_cmp;
   int m_pc, m_cnt, m_upd;

   always #4 clk = ~clk;

   trig_timer u_trig_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_out(trig_out), .cmp_ref(cmp_ref), .cnt_out(cnt_out));

   function automatic int exp_ref();
      case (m_mode)
         0: return 0;
         1: return 1;
         2: return (m_cnt < m_cmp) ? 1 : 0;
         default: return (m_cnt >= m_cmp) ? 1 : 0;
      endcase
   endfunction

   function automatic int exp_trig();
      if (m_src >= 4) return exp_ref();
      if (m_src == 2) return m_upd;
      return 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
      end
   endtask

   // reference model: steps on each rising edge with the inputs seen before it
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_en = 0; m_src = 0; m_mode = 0; m_psc_pre = 0; m_psc_sh = 0;
         m_arr_pre = 65535; m_arr_sh = 65535; m_cmp = 0; m_pc = 0; m_cnt = 0; m_upd = 0;
      end else begin
         int tk, wrap;
         tk = (m_en != 0 && m_pc >= m_psc_sh) ? 1 : 0;
         wrap = (tk != 0 && m_cnt == m_arr_sh) ? 1 : 0;
         if (m_en != 0) m_pc = tk ? 0 : (m_pc + 1) % 65536;
         m_upd = wrap;
         if (wrap) m_cnt = 0;
         else if (tk) m_cnt = m_cnt + 1;
         if (wrap || m_en == 0) begin
            m_psc_sh = m_psc_pre;
            m_arr_sh = m_arr_pre;
         end
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin m_en = wr_data[0]; m_src = wr_data[3:1]; m_mode = wr_data[5:4]; end
               2'd1: m_psc_pre = wr_data;
               2'd2: m_arr_pre = wr_data;
               default: m_cmp = wr_data;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 cnt", cnt_out, m_cnt);
         chk("R7/R10 ref", cmp_ref, exp_ref());
         if (m_src >= 4) chk("R5 trig", trig_out, exp_trig());
         else if (m_src == 2) chk("R4 trig", trig_out, exp_trig());
         else chk("R6 trig", trig_out, exp_trig());
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_trig_rise(output int at);
      while (trig_out) @(negedge clk);
      while (!trig_out) @(negedge clk);
      at = cyc;
   endtask

   initial begin
      int t0, t1;
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cnt", cnt_out, 0);
      chk("R1 trig", trig_out, 0);
      chk("R1 ref", cmp_ref, 0);

      // R3/R4: arr 9, psc 2, compare 4 PWM, update trigger
      wr(2, 9); wr(1, 2); wr(3, 4);
      wr(0, (2 << 4) | (3'b010 << 1) | 1);
      wait_trig_rise(t0);
      chk("R4 trig at zero", cnt_out, 0);
      wait_trig_rise(t1);
      chk("R4 R3 pulse spacing", t1 - t0, 30);
      c0 = cnt_out;
      idle(3);
      chk("R3 one count per 3 clocks", cnt_out, c0 + 1);

      // R8: new prescaler while running waits for update
      wr(1, 0);
      c0 = cnt_out;
      idle(2);
      chk("R8 old prescaler still in force", (cnt_out - c0) <= 1 ? 1 : 0, 1);
      wait_trig_rise(t0);
      @(negedge clk);
      chk("R8 new prescaler after update", cnt_out, 1);
      idle(25);

      // R5: reference as trigger, inverted PWM, then R10 compare change
      wr(0, (3 << 4) | (3'b100 << 1) | 1);
      idle(25);
      wr(3, 7);
      chk("R10 cmp seen next cycle", cmp_ref, (cnt_out >= 7) ? 1 : 0);
      wr(0, (2 << 4) | (3'b111 << 1) | 1);
      idle(25);

      // R6: disabled trigger sources
      wr(0, (1 << 4) | (3'b000 << 1) | 1);
      idle(20);
      wr(0, (0 << 4) | (3'b011 << 1) | 1);
      idle(20);
      wr(0, (2 << 4) | (3'b001 << 1) | 1);
      idle(20);

      // R9: stop holds counter, no pulses
      wr(0, (2 << 4) | (3'b010 << 1) | 0);
      c0 = cnt_out;
      idle(30);
      chk("R9 counter held", cnt_out, c0);
      chk("R9 no trigger", trig_out, 0);

      // R2/R4 corner: arr 0, psc 0 -> wraps every clock
      wr(2, 0); wr(1, 0);
      wr(0, (2 << 4) | (3'b010 << 1) | 1);
      idle(10);
      chk("R2 arr zero keeps zero", cnt_out, 0);
      chk("R4 continuous updates", trig_out, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule